// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus when a slave device is stuck partway through a byte and is holding SDA low. It sits between the normal I2C controller and the open-drain pad drivers. While idle it passes the controller's pull-down enables straight to the pins. On a start request it disables the controller and takes both lines. It then clocks SCL nine times with SDA left floating, so the stuck slave shifts out its remaining bits and reads one of the cycles as a not-acknowledge. After the pulses it forms a STOP condition and hands the pins back.

Every SCL low phase and high phase is timed by a programmable half-period count. The high phase starts counting only after the synchronised SCL input reads high, so a slave that stretches the clock or a slow rising edge only makes the pulse longer. After the STOP, the sampled SDA level sets either a released flag or a stuck flag. A one-cycle done pulse marks the end of the sequence.

Top module: `i2c_bus_clear`

## Requirements
- R1: While `busy_o` is 1, `ctl_en_o` is 0 and `scl_oe_o`/`sda_oe_o` ignore the controller inputs. While idle, `ctl_en_o` is 1, `scl_oe_o` equals `ctl_scl_oe_i` and `sda_oe_o` equals `ctl_sda_oe_i`. An output enable of 1 pulls its line low.
- R2: Each accepted start produces exactly nine SCL clock pulses followed by a STOP. That gives ten SCL low phases and ten SCL rising edges in total, whenever the slave lets go of SDA.
- R3: `sda_oe_o` stays 0 through all nine clock pulses (their low and high phases).
- R4: The STOP pulls SDA low only in a cycle where SCL is pulled low. It releases SDA only while the SCL line is high, and SCL is not pulled low again before done.
- R5: Each SCL low phase lasts exactly `half_div_i + 1` clock cycles, using the value captured at start. `half_div_i` must be at least 2 when a start is accepted.
- R6: Each clock-pulse high phase is timed from the synchronised SCL input. The line stays high for exactly `half_div_i + 4` cycles from its rising edge: two synchroniser stages, one decision cycle and the `half_div_i + 1` cycle phase. A slave that stretches the clock delays the pulse but does not shorten it.
- R7: At the end of the sequence, `sda_ok_o` is set if the synchronised SDA reads high and `sda_stuck_o` is set if it reads low. Both flags hold until the next accepted start, which clears them.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is 0 in the following cycle. A start request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, accepted only when idle |
| half_div_i | input | DIV_W | Half-period length minus one, in clock cycles |
| ctl_scl_oe_i | input | 1 | Controller SCL pull-down enable |
| ctl_sda_oe_i | input | 1 | Controller SDA pull-down enable |
| scl_i | input | 1 | SCL pin level (asynchronous) |
| sda_i | input | 1 | SDA pin level (asynchronous) |
| ctl_en_o | output | 1 | Enable for the normal controller, low during recovery |
| scl_oe_o | output | 1 | SCL pull-down enable to the pad |
| sda_oe_o | output | 1 | SDA pull-down enable to the pad |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| sda_ok_o | output | 1 | SDA read high after the STOP |
| sda_stuck_o | output | 1 | SDA still low after the STOP |

## Verification
The bench models a slave that keeps SDA low until it has seen a chosen number of SCL rising edges (zero, partway, at the STOP, or never), and optionally stretches one clock pulse. One corner case is a slave that releases SDA at once. A design that stopped clocking early would then show fewer than ten SCL rises. Another is a stretched pulse: a design that timed the high phase from its own release instead of from the sampled line would give a short high phase. The STOP edges are checked against the SCL line, so a STOP formed with SCL low or with the edges swapped is caught. A second start pulse in mid-run would show up as an extra done or a restarted pulse train.

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int DIV_W      = 16,
  parameter int NUM_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             ctl_scl_oe_i,
  input  logic             ctl_sda_oe_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             ctl_en_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sda_ok_o,
  output logic             sda_stuck_o
);
  localparam int CNT_W = $clog2(NUM_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOW, S_HWAIT, S_HIGH, S_PLOW, S_PRISE, S_PHIGH, S_PREL, S_DONE
  } st_t;

  st_t              st;
  logic [1:0]       scl_sq, sda_sq;
  logic [DIV_W-1:0] hq, tmr;
  logic [CNT_W-1:0] pcnt;
  logic             ok_q, stuck_q;

  wire scl_s   = scl_sq[1];
  wire sda_s   = sda_sq[1];
  wire tmr_end = (tmr == '0);
  wire rec_scl = (st == S_LOW) || (st == S_PLOW);
  wire rec_sda = (st == S_PLOW) || (st == S_PRISE) || (st == S_PHIGH);

  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_DONE);
  assign ctl_en_o    = ~busy_o;
  assign scl_oe_o    = busy_o ? rec_scl : ctl_scl_oe_i;
  assign sda_oe_o    = busy_o ? rec_sda : ctl_sda_oe_i;
  assign sda_ok_o    = ok_q;
  assign sda_stuck_o = stuck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sq <= 2'b11;
      sda_sq <= 2'b11;
    end else begin
      scl_sq <= {scl_sq[0], scl_i};
      sda_sq <= {sda_sq[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hq      <= '0;
      tmr     <= '0;
      pcnt    <= '0;
      ok_q    <= 1'b0;
      stuck_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          st      <= S_LOW;
          hq      <= half_div_i;
          tmr     <= half_div_i;
          pcnt    <= '0;
          ok_q    <= 1'b0;
          stuck_q <= 1'b0;
        end
        S_LOW:
          if (tmr_end) st <= S_HWAIT;
          else         tmr <= tmr - 1'b1;
        S_HWAIT: if (scl_s) begin
          st  <= S_HIGH;
          tmr <= hq;
        end
        S_HIGH:
          if (tmr_end) begin
            pcnt <= pcnt + 1'b1;
            tmr  <= hq;
            st   <= (pcnt == CNT_W'(NUM_PULSES - 1)) ? S_PLOW : S_LOW;
          end else tmr <= tmr - 1'b1;
        S_PLOW:
          if (tmr_end) st <= S_PRISE;
          else         tmr <= tmr - 1'b1;
        S_PRISE: if (scl_s) begin
          st  <= S_PHIGH;
          tmr <= hq;
        end
        S_PHIGH:
          if (tmr_end) begin
            st  <= S_PREL;
            tmr <= hq;
          end else tmr <= tmr - 1'b1;
        S_PREL:
          if (tmr_end) begin
            st      <= S_DONE;
            ok_q    <= sda_s;
            stuck_q <= ~sda_s;
          end else tmr <= tmr - 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SDA_FREE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW || st == S_HWAIT || st == S_HIGH) |-> !sda_oe_o); // R3
  AST_STOP_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $rose(sda_oe_o)) |-> scl_oe_o); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $fell(sda_oe_o)) |-> scl_s); // R4
  AST_NINE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PLOW) |-> (pcnt == CNT_W'(NUM_PULSES))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R8
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sda_ok_o ^ sda_stuck_o)); // R7
  AST_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |-> (half_div_i >= DIV_W'(2))); // R5
endmodule

// File: tb/i2c_bus_clear_tb.sv
module i2c_bus_clear_tb;
  localparam int DIV_W = 16;

  typedef struct { int half; bit ok; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [DIV_W-1:0] half_div_i = 16'd3;
  logic ctl_scl_oe_i = 1'b0, ctl_sda_oe_i = 1'b0;
  logic ctl_en_o, scl_oe_o, sda_oe_o, busy_o, done_o, sda_ok_o, sda_stuck_o;
  logic scl_line, sda_line;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];

  // slave model
  bit case_active = 0;
  int stuck_for = -1, stretch_at = -1, stretch_len = 0;
  int slv_rises = 0, st_cnt = 0;
  logic slv_prev_scl = 1'b1;
  wire slv_scl_hold = (st_cnt > 0);
  wire slv_sda_hold = case_active && (stuck_for < 0 || slv_rises < stuck_for);

  assign scl_line = !(scl_oe_o || slv_scl_hold);
  assign sda_line = !(sda_oe_o || slv_sda_hold);

  always #5 clk = ~clk;

  i2c_bus_clear #(.DIV_W(DIV_W), .NUM_PULSES(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
    .ctl_scl_oe_i(ctl_scl_oe_i), .ctl_sda_oe_i(ctl_sda_oe_i),
    .scl_i(scl_line), .sda_i(sda_line), .ctl_en_o(ctl_en_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .done_o(done_o), .sda_ok_o(sda_ok_o), .sda_stuck_o(sda_stuck_o));

  always @(posedge clk) begin
    slv_prev_scl <= scl_line;
    if (!busy_o) slv_rises <= 0;
    else if (scl_line && !slv_prev_scl) slv_rises <= slv_rises + 1;
    if (busy_o && scl_oe_o && slv_rises == stretch_at) st_cnt <= stretch_len;
    else if (st_cnt > 0) st_cnt <= st_cnt - 1;
  end

  task automatic check(input bit cond, input string req, input int act, input int expv);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor
  int lo_len, hi_len, low_runs, hi_pulses, rises, lo_err, hi_err, sda_err, stop_err, ctl_err;
  int rel_seen, done_total = 0;
  logic p_busy = 0, p_sda_oe = 0, p_scl_line = 1;
  bit chk_idle = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_idle) begin
        chk_idle = 0;
        check(!busy_o && !done_o, "R8 busy after done", busy_o, 0);
      end
      if (busy_o && !p_busy) begin
        lo_len = 0; hi_len = 0; low_runs = 0; hi_pulses = 0; rises = 0;
        lo_err = 0; hi_err = 0; sda_err = 0; stop_err = 0; ctl_err = 0; rel_seen = 0;
      end
      if (busy_o && q.size() > 0) begin
        if (ctl_en_o) ctl_err++;
        if (scl_line && !p_scl_line && p_busy) rises++;
        if (scl_oe_o) lo_len++;
        else if (lo_len > 0) begin
          if (lo_len != q[0].half + 1) lo_err++;
          low_runs++; lo_len = 0;
        end
        if (!scl_oe_o && scl_line) hi_len++;
        else if (scl_oe_o && hi_len > 0) begin
          if (hi_len != q[0].half + 4) hi_err++;
          hi_pulses++; hi_len = 0;
        end else if (!scl_line) hi_len = 0;
        if (sda_oe_o && (low_runs < 9 || (low_runs == 9 && !scl_oe_o))) sda_err++;
        if (p_busy && sda_oe_o && !p_sda_oe && !scl_oe_o) stop_err++;
        if (p_busy && !sda_oe_o && p_sda_oe) begin
          if (!scl_line) stop_err++;
          rel_seen++;
        end
        if (rel_seen > 0 && scl_oe_o) stop_err++;
      end
      if (done_o) begin
        done_total++;
        if (q.size() == 0) check(0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(rises == 10, "R2 SCL rising edges", rises, 10);
          check(low_runs == 10, "R2 SCL low phases", low_runs, 10);
          check(lo_err == 0, "R5 low phase length", lo_err, 0);
          check(hi_pulses == 9 && hi_err == 0, "R6 high phase length", hi_err, 0);
          check(sda_err == 0, "R3 SDA driven during pulses", sda_err, 0);
          check(stop_err == 0 && rel_seen == 1, "R4 STOP edges", stop_err, 0);
          check(ctl_err == 0, "R1 controller enabled while busy", ctl_err, 0);
          check(sda_ok_o == e.ok && sda_stuck_o == !e.ok, "R7 flags",
                {sda_ok_o, sda_stuck_o}, {e.ok, !e.ok});
          chk_idle = 1;
        end
      end
      p_busy = busy_o; p_sda_oe = sda_oe_o; p_scl_line = scl_line;
    end
  end

  // driver
  task automatic run_case(input int half, input int sf, input int sa, input int sl, input bit again);
    exp_t e;
    int dstart;
    e.half = half;
    e.ok = (sf >= 0 && sf <= 10);
    dstart = done_total;
    stuck_for = sf; stretch_at = sa; stretch_len = sl; case_active = 1;
    q.push_back(e);
    @(negedge clk);
    half_div_i = DIV_W'(half);
    ctl_scl_oe_i = 1; ctl_sda_oe_i = 1;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(busy_o && !sda_ok_o && !sda_stuck_o, "R7 flags cleared on start",
          {busy_o, sda_ok_o, sda_stuck_o}, 3'b100);
    if (again) begin
      repeat (40) @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    ctl_scl_oe_i = 0; ctl_sda_oe_i = 0; case_active = 0;
    repeat (20) @(negedge clk);
    check(done_total == dstart + 1 && !busy_o, "R8 single done per start",
          done_total - dstart, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && ctl_en_o && !sda_ok_o && !sda_stuck_o,
              "R1 reset state", {busy_o, done_o, ctl_en_o}, 3'b001);
        rst_n = 1;
        @(negedge clk);
        ctl_scl_oe_i = 1; ctl_sda_oe_i = 0;
        @(negedge clk);
        check(scl_oe_o && !sda_oe_o && ctl_en_o, "R1 idle pass-through a",
              {scl_oe_o, sda_oe_o}, 2'b10);
        ctl_scl_oe_i = 0; ctl_sda_oe_i = 1;
        @(negedge clk);
        check(!scl_oe_o && sda_oe_o && ctl_en_o, "R1 idle pass-through b",
              {scl_oe_o, sda_oe_o}, 2'b01);
        ctl_sda_oe_i = 0;
        run_case(3, 3, -1, 0, 0);
        run_case(5, -1, -1, 0, 0);
        run_case(4, 0, -1, 0, 0);
        run_case(2, 9, 4, 7, 0);
        run_case(3, 2, -1, 0, 1);
        run_case(6, 10, 8, 3, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule